// File: doc/BRIEF.md
# Ready/Valid Byte Escaper

This block inserts escape sequences into a byte stream so that a small set of reserved byte values never appears in the payload. The downstream receiver can then use those values as frame markers. Each upstream element carries a byte and a flag. The flag says whether the byte belongs to the payload, which may be escaped, or to framing, which is passed untouched. When a payload byte equals one of the reserved values, the block sends two bytes in its place: a fixed prefix, then the original byte with its top bit inverted. Every other byte leaves as a single byte with its value unchanged.

Both sides use valid/ready handshakes, so any byte consumer, such as a serial transmitter, can drain the output. The output sits in a single registered slot, which keeps the downstream timing clean. While the second byte of an escape pair is waiting, the upstream side is held off. With no escapes and no downstream stalls, the block moves one byte per clock.

Top module: `esc_stuffer`

## Requirements
- R1: An accepted byte with `in_esc`=1 and value 0xFF leaves as two consecutive output bytes, 0xFE then 0x7F.
- R2: An accepted byte with `in_esc`=1 and value 0xFE leaves as two consecutive output bytes, 0xFE then 0x7E.
- R3: An accepted byte with `in_esc`=0 leaves as exactly one output byte of the same value, including 0xFF and 0xFE.
- R4: An accepted byte with `in_esc`=1 that is neither 0xFF nor 0xFE (for example 0x7F or 0x7E) leaves as exactly one output byte of the same value.
- R5: Output bytes keep the order of the accepted input. Under any pattern of downstream stalls, no byte is lost and no byte is duplicated.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` holds its value on the next cycle.
- R7: After an escapable reserved byte is accepted, `in_ready` stays 0 until the second byte of the pair has been handed downstream.
- R8: With `out_ready` held at 1 and no escapes, the block accepts a byte on every clock cycle. An accepted byte appears on `out_data` in the cycle after its input handshake.
- R9: A synchronous reset (`rst`=1 at a clock edge) drops `out_valid` to 0, discards any pending second byte, and leaves `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream element valid |
| in_esc | input | 1 | 1 = payload byte that may be escaped, 0 = framing byte passed untouched |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Block can take the upstream element this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream takes the output byte this cycle |

## Verification
An input handshake at one rising edge puts its first output byte on the port right after that edge. So the byte is visible one cycle later, and `in_ready` falls in that same cycle when an escape pair starts. The second byte of a pair appears one cycle after the downstream handshake on the prefix.

The bench decides every handshake half a cycle ahead, reading `in_ready` or `out_valid`/`out_ready` just after the falling edge. It books the expected bytes in a queue at that point and pops them only when it sees an output handshake. Because of this, the random stall patterns never shift where a result is compared. The stall-hold and reset checks sample a fixed number of falling edges after the handshake that set them up.

// File: rtl/esc_pkg.sv
package esc_pkg;

   // Output slot occupancy
   typedef enum logic [1:0] {
      SLOT_EMPTY  = 2'd0,
      SLOT_SINGLE = 2'd1,   // one byte, nothing behind it
      SLOT_LEAD   = 2'd2    // prefix shown, transformed byte held
   } slot_e;

   // True when CODE is one of the COUNT values packed in LIST
   function automatic bit list_has(input int unsigned code,
                                   input logic [255:0] list,
                                   input int unsigned count,
                                   input int unsigned width);
      bit found;
      found = 1'b0;
      for (int i = 0; i < int'(count); i++) begin
         if (((list >> (i * width)) & ((256'd1 << width) - 1)) == 256'(code))
            found = 1'b1;
      end
      return found;
   endfunction

endpackage

// File: rtl/esc_match.sv
module esc_match #(
   parameter int unsigned        BYTE_W  = 8,
   parameter int unsigned        N_CODES = 2,
   parameter logic [255:0]       CODES   = 256'h0000_FEFF
) (
   input  logic [BYTE_W-1:0] byte_i,
   output logic              hit_o
);

   localparam int unsigned LIST_W = N_CODES * BYTE_W;

   logic [N_CODES-1:0] eq;

   generate
      if (N_CODES == 1) begin : g_single
         assign eq[0] = (byte_i == CODES[BYTE_W-1:0]);
      end else begin : g_multi
         for (genvar k = 0; k < int'(N_CODES); k++) begin : g_cmp
            assign eq[k] = (byte_i == CODES[k*BYTE_W +: BYTE_W]);
         end
      end
   endgenerate

   logic unused_ok;
   assign unused_ok = (LIST_W > 0);
   assign hit_o = |eq;

endmodule

// File: rtl/esc_core.sv
module esc_core
   import esc_pkg::*;
#(
   parameter int unsigned        BYTE_W  = 8,
   parameter logic [BYTE_W-1:0]  PREFIX  = 8'hFE,
   parameter logic [BYTE_W-1:0]  FLIP    = 8'h80
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              need_esc,
   input  logic [BYTE_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   input  logic              out_ready
);

   slot_e             slot_q;
   logic [BYTE_W-1:0] show_q;
   logic [BYTE_W-1:0] held_q;
   logic              drain;
   logic              take;

   assign drain     = (slot_q != SLOT_EMPTY) && out_ready;
   assign in_ready  = (slot_q != SLOT_LEAD) && ((slot_q == SLOT_EMPTY) || out_ready);
   assign take      = in_valid && in_ready;
   assign out_valid = (slot_q != SLOT_EMPTY);
   assign out_data  = show_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q <= SLOT_EMPTY;
         show_q <= '0;
         held_q <= '0;
      end else if (slot_q == SLOT_LEAD) begin
         if (out_ready) begin
            slot_q <= SLOT_SINGLE;
            show_q <= held_q;
         end
      end else if (take) begin
         if (need_esc) begin
            slot_q <= SLOT_LEAD;
            show_q <= PREFIX;
            held_q <= in_data ^ FLIP;
         end else begin
            slot_q <= SLOT_SINGLE;
            show_q <= in_data;
         end
      end else if (drain) begin
         slot_q <= SLOT_EMPTY;
      end
   end

endmodule

// File: rtl/esc_stuffer.sv
module esc_stuffer
   import esc_pkg::*;
#(
   parameter int unsigned        BYTE_W  = 8,
   parameter int unsigned        N_CODES = 2,
   parameter logic [255:0]       CODES   = 256'h0000_FEFF,
   parameter logic [BYTE_W-1:0]  PREFIX  = 8'hFE,
   parameter logic [BYTE_W-1:0]  FLIP    = 8'h80
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_esc,
   input  logic [BYTE_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   input  logic              out_ready
);

   localparam bit PREFIX_RESERVED = list_has(int'(PREFIX), CODES, N_CODES, BYTE_W);

   generate
      if (BYTE_W < 2 || BYTE_W > 32) begin : g_bad_width
         $error("esc_stuffer: BYTE_W out of range");
      end
      if (N_CODES < 1 || N_CODES * BYTE_W > 256) begin : g_bad_count
         $error("esc_stuffer: N_CODES out of range");
      end
      if (!PREFIX_RESERVED) begin : g_bad_prefix
         $error("esc_stuffer: PREFIX must be a reserved code");
      end
      if (FLIP == '0) begin : g_bad_flip
         $error("esc_stuffer: FLIP must change the byte");
      end
   endgenerate

   logic hit;
   logic need_esc;

   esc_match #(
      .BYTE_W (BYTE_W),
      .N_CODES(N_CODES),
      .CODES  (CODES)
   ) u_match (
      .byte_i(in_data),
      .hit_o (hit)
   );

   assign need_esc = in_esc && hit;

   esc_core #(
      .BYTE_W(BYTE_W),
      .PREFIX(PREFIX),
      .FLIP  (FLIP)
   ) u_core (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .need_esc (need_esc),
      .in_data  (in_data),
      .in_ready (in_ready),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_ready(out_ready)
   );

endmodule

// File: rtl/esc_stuffer_chk.sv
module esc_stuffer_chk #(
   parameter int unsigned        BYTE_W  = 8,
   parameter int unsigned        N_CODES = 2,
   parameter logic [255:0]       CODES   = 256'h0000_FEFF,
   parameter logic [BYTE_W-1:0]  PREFIX  = 8'hFE
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_esc,
   input logic [BYTE_W-1:0] in_data,
   input logic              in_ready,
   input logic              out_valid,
   input logic [BYTE_W-1:0] out_data,
   input logic              out_ready
);

   logic reserved;
   always_comb begin
      reserved = 1'b0;
      for (int i = 0; i < int'(N_CODES); i++)
         if (in_data == CODES[i*BYTE_W +: BYTE_W]) reserved = 1'b1;
   end

   logic acc_esc, acc_plain;
   assign acc_esc   = in_valid && in_ready && in_esc && reserved;
   assign acc_plain = in_valid && in_ready && !(in_esc && reserved);

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6

   AST_PREFIX_FIRST: assert property (@(posedge clk) disable iff (rst)
      acc_esc |=> out_valid && out_data == PREFIX); // R1

   AST_INPUT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      acc_esc |=> !in_ready); // R7

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
      acc_plain |=> out_valid && out_data == $past(in_data)); // R3

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> !out_valid && in_ready); // R9

endmodule

bind esc_stuffer esc_stuffer_chk #(
   .BYTE_W (BYTE_W),
   .N_CODES(N_CODES),
   .CODES  (CODES),
   .PREFIX (PREFIX)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_esc   (in_esc),
   .in_data  (in_data),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_data (out_data),
   .out_ready(out_ready)
);

// File: tb/sim_esc_stuffer.sv
`timescale 1ns/1ps
module sim_esc_stuffer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic       in_esc = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_ready = 1'b0;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int rdy_mode = 1;            // 0 random, 1 always, 2 never
   logic [7:0] exp_q[$];
   string      tag_q[$];
   int         acc_cyc[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   esc_stuffer u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_esc(in_esc),
      .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
      .out_data(out_data), .out_ready(out_ready)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // Downstream ready pattern
   initial forever begin
      @(negedge clk);
      case (rdy_mode)
         0: out_ready = ($urandom_range(0, 3) != 0);
         1: out_ready = 1'b1;
         default: out_ready = 1'b0;
      endcase
   end

   // Monitor: pop on every output handshake
   initial forever begin
      @(negedge clk);
      #2;
      if (!rst && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected byte", out_data, 0);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_data == e, t, out_data, e);
         end
      end
   end

   task automatic expect_byte(input logic [7:0] b, input string tag);
      exp_q.push_back(b);
      tag_q.push_back(tag);
   endtask

   task automatic send(input logic [7:0] b, input logic e, input string tag);
      bit done;
      done = 1'b0;
      while (!done) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = b;
         in_esc   = e;
         #1;
         if (in_ready && !rst) begin
            if (e && (b == 8'hFF || b == 8'hFE)) begin
               expect_byte(8'hFE, tag);
               expect_byte(b ^ 8'h80, tag);
            end else begin
               expect_byte(b, tag);
            end
            acc_cyc.push_back(cyc);
            done = 1'b1;
         end
      end
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic drain(input string tag);
      rdy_mode = 0;
      for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, tag, exp_q.size(), 0);
   endtask

   // Watchdog
   initial begin
      #1500000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
      rst = 1'b0;
      @(negedge clk);
      #1;
      check(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);

      // R8: back-to-back plain bytes with ready held high
      rdy_mode = 1;
      acc_cyc.delete();
      for (int i = 0; i < 5; i++) send(8'h10 + 8'(i), 1'b1, "R8 stream");
      for (int i = 1; i < 5; i++)
         check(acc_cyc[i] - acc_cyc[i-1] == 1, "R8 one per clock",
               acc_cyc[i] - acc_cyc[i-1], 1);
      // R8 latency: first output right after handshake
      @(negedge clk);
      send(8'h55, 1'b0, "R8 latency");
      #1;
      check(out_valid && out_data == 8'h55, "R8 latency", out_data, 8'h55);
      drain("R5 drain stream");

      // Corner values with random stalls
      rdy_mode = 0;
      send(8'h7F, 1'b1, "R4 esc 7F");
      send(8'hFF, 1'b1, "R1 esc FF");
      send(8'hFF, 1'b0, "R3 raw FF");
      send(8'hFE, 1'b1, "R2 esc FE");
      send(8'hFE, 1'b0, "R3 raw FE");
      send(8'h7E, 1'b1, "R4 esc 7E");
      send(8'h00, 1'b1, "R4 esc 00");
      drain("R5 drain corners");

      // R7 / R6: pair held under full stall
      rdy_mode = 2;
      send(8'hFF, 1'b1, "R1 stalled pair");
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         check(in_ready == 1'b0, "R7 input held", in_ready, 0);
         check(out_valid && out_data == 8'hFE, "R6 hold prefix", out_data, 8'hFE);
      end
      rdy_mode = 1;
      @(negedge clk);   // prefix taken at next edge
      @(negedge clk);
      #1;
      check(in_ready == 1'b0 || out_data == 8'h7F, "R7 second byte shown", out_data, 8'h7F);
      drain("R5 drain stalled pair");

      // Random mixed traffic
      rdy_mode = 0;
      for (int i = 0; i < 300; i++) begin
         logic [7:0] b;
         logic e;
         b = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 0) ? 8'hFF : 8'hFE)
                                          : 8'($urandom_range(0, 255));
         e = 1'($urandom_range(0, 1));
         send(b, e, e ? "R1 R2 R4 random" : "R3 random");
      end
      drain("R5 drain random");

      // R9: reset while a second byte is pending
      rdy_mode = 2;
      send(8'hFE, 1'b1, "R9 pre-reset");
      @(negedge clk);
      rst = 1'b1;
      exp_q.delete();
      tag_q.delete();
      @(negedge clk);
      rst = 1'b0;
      #1;
      check(out_valid == 1'b0, "R9 valid cleared", out_valid, 0);
      check(in_ready == 1'b1, "R9 ready restored", in_ready, 1);
      rdy_mode = 1;
      repeat (3) @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R9 pending discarded", out_valid, 0);
      send(8'h42, 1'b1, "R9 after reset");
      drain("R5 drain final");

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule